// File: doc/BRIEF.md
# Shared receive FIFO with automatic XON/XOFF flow control

This block is the common receive buffer of a multi-line serial controller. Every line pushes received characters into one FIFO of 16-bit words. Each word is tagged with its line number and marked as either a data byte or a modem-status change record. The host pops words through a simple read port. If the FIFO is empty, the read port shows an all-zero word.

Flow control is built into the buffer. When the fill level climbs to two thirds of capacity, the block raises a request to send XOFF (0x13) on all lines. When the level later drains to half, it requests XON (0x11) on all lines. Each line also has a force-XOFF control bit:

- Raising the bit requests XOFF at once.
- While the bit stays high, every second character received on that line requests another XOFF.
- Lowering the bit requests XON.

Requests are presented one at a time to the transmit side, each with a line mask, and are held until acknowledged. The modem inputs CTS, DSR and DCD of each line are sampled once per fixed interval, which defaults to 10 ms at 200 MHz. A changed sample is logged into the FIFO.

Top module: `rx_silo`

## Requirements
- R1: A data word reads as 0x8000 | line<<8 | byte. A status word reads as 0x9000 | line<<8 | {DCD,DSR,CTS} in bits 2:0, with bit 12 as the status flag. An empty FIFO reads as 0x0000.
- R2: Words are read in arrival order. A read pulse (rdEn) removes the word shown on rdData. A read pulse on an empty FIFO has no effect.
- R3: The FIFO holds DEPTH words. A push into a full FIFO is dropped and sets overrun. Overrun stays set until an ovrClr pulse.
- R4: When the fill level reaches floor(2*DEPTH/3), one XOFF request with flowMask all ones is raised. Further pushes raise no further XOFF.
- R5: After a threshold XOFF, an XON request with flowMask all ones is raised once the fill level drops to DEPTH/2 or below, and not before.
- R6: A rising forceXoff bit for a line requests XOFF with flowMask one-hot on that line.
- R7: While a line's forceXoff bit is high, the 2nd, 4th, 6th and later characters received on that line each request XOFF on that line. Characters on other lines do not count.
- R8: A falling forceXoff bit requests XON with flowMask one-hot on that line.
- R9: flowReq, flowChar and flowMask stay unchanged until flowAck. Force requests are granted before threshold requests, and lower line numbers are granted first.
- R10: Modem inputs are sampled every SAMPLE_PERIOD cycles. A status word is logged for a line only when its sample differs from the previous one. The sample before the first interval is all zeros.
- R11: A received character is pushed ahead of a pending status word in the same cycle. The status word is pushed later and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | A received character is present this cycle |
| rxLine | input | LW | Line number of the received character |
| rxData | input | 8 | Received character |
| modemIn | input | 3*NUM_LINES | Per line {DCD,DSR,CTS}; line n uses bits 3n+2:3n |
| rdEn | input | 1 | Host read pulse, removes the word on rdData |
| rdData | output | 16 | Oldest word, or 0 when empty |
| ovrClr | input | 1 | Host write that clears overrun |
| overrun | output | 1 | Sticky: a push was dropped because the FIFO was full |
| forceXoff | input | NUM_LINES | Per-line force-XOFF control bits |
| flowReq | output | 1 | A flow-control character is requested |
| flowChar | output | 8 | 0x13 for XOFF, 0x11 for XON |
| flowMask | output | NUM_LINES | Lines on which to send flowChar |
| flowAck | input | 1 | Transmit side accepts the current request |

## Verification
The bench runs a small 12-word configuration, so the XOFF point is 8 and the XON point is 6. It walks the fill level through both thresholds and into overflow. A design with a wrong threshold, or without hysteresis, raises its request one word early or late, or repeats XOFF. A design that does not drop the push into a full FIFO overwrites the oldest word, which shows up as an out-of-order read.

Force-XOFF parity is counted across interleaved characters from other lines, where a shared counter or an odd-character trigger gives a misplaced XOFF. A threshold request and a force request are queued together behind an unacknowledged request, which exposes a wrong grant order or a request that changes before acknowledgement. The modem sampler is run under a continuous stream of received characters, where a status word that is overwritten or dropped goes missing from the drained FIFO.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

  localparam logic [7:0] CHAR_XOFF = 8'h13;
  localparam logic [7:0] CHAR_XON  = 8'h11;

  typedef struct packed {
    logic        push;
    logic [15:0] word;
    logic        pop;
    logic        clrOvr;
  } siloStrobe_t;

  function automatic logic [15:0] makeEntry(input logic isStatus,
                                            input logic [3:0] line,
                                            input logic [7:0] payload);
    return {1'b1, 2'b00, isStatus, line, payload};
  endfunction

endpackage

// File: rtl/rx_silo_data.sv
module rx_silo_data
  import rx_silo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  siloStrobe_t   strobe,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic [15:0]   headWord,
  output logic          overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [15:0]   mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          full, popOk, pushOk;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign popOk  = strobe.pop && !empty;
  assign pushOk = strobe.push && (!full || popOk);
  assign headWord = empty ? 16'h0000 : mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= strobe.word;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strobe.push && !pushOk) overrun <= 1'b1;
      else if (strobe.clrOvr)     overrun <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    full && strobe.push && !strobe.pop |=> full && overrun); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !strobe.clrOvr |=> overrun); // R3
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    empty && !strobe.push |=> empty && headWord == 16'h0000); // R2

endmodule

// File: rtl/rx_silo_ctrl.sv
module rx_silo_ctrl
  import rx_silo_pkg::*;
#(
  parameter int DEPTH         = 256,
  parameter int NUM_LINES     = 8,
  parameter int SAMPLE_PERIOD = 2000000,
  parameter int LW            = 3,
  parameter int CW            = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rxValid,
  input  logic [LW-1:0]          rxLine,
  input  logic [7:0]             rxData,
  input  logic [3*NUM_LINES-1:0] modemIn,
  input  logic                   rdEn,
  input  logic                   ovrClr,
  input  logic [NUM_LINES-1:0]   forceXoff,
  input  logic                   flowAck,
  input  logic [CW-1:0]          count,
  input  logic                   empty,
  output siloStrobe_t            strobe,
  output logic                   flowReq,
  output logic [7:0]             flowChar,
  output logic [NUM_LINES-1:0]   flowMask
);
  localparam int HIGH_MARK = (2 * DEPTH) / 3;
  localparam int LOW_MARK  = DEPTH / 2;
  localparam int TW        = $clog2(SAMPLE_PERIOD);

  // ---------------- force-XOFF per line ----------------
  logic [NUM_LINES-1:0] forcePrev, parity, forceEvt, forceEvtXon;
  logic [NUM_LINES-1:0] forcePend, forcePendXon, forceGrant;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic rise, fall, hit;
    assign rise = forceXoff[g] & ~forcePrev[g];
    assign fall = ~forceXoff[g] & forcePrev[g];
    assign hit  = forceXoff[g] & forcePrev[g] & rxValid & (rxLine == LW'(g));
    assign forceEvt[g]    = rise | fall | (hit & parity[g]);
    assign forceEvtXon[g] = fall;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        forcePrev[g] <= 1'b0;
        parity[g]    <= 1'b0;
      end else begin
        forcePrev[g] <= forceXoff[g];
        if (rise)     parity[g] <= 1'b0;
        else if (hit) parity[g] <= ~parity[g];
      end
    end
  end

  // ---------------- threshold hysteresis ----------------
  logic autoOn, autoEvt, autoEvtXon, autoPend, autoPendXon;
  assign autoEvt    = (!autoOn && count >= CW'(HIGH_MARK)) ||
                      (autoOn && count <= CW'(LOW_MARK));
  assign autoEvtXon = autoOn;

  // ---------------- request arbiter ----------------
  logic          loadReq, anyForce;
  logic [LW-1:0] forceSel;
  assign loadReq = !flowReq || flowAck;

  always_comb begin
    anyForce = 1'b0;
    forceSel = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (forcePend[i]) begin
        anyForce = 1'b1;
        forceSel = LW'(i);
      end
    end
    forceGrant = '0;
    if (loadReq && anyForce) forceGrant[forceSel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      autoOn       <= 1'b0;
      autoPend     <= 1'b0;
      autoPendXon  <= 1'b0;
      forcePend    <= '0;
      forcePendXon <= '0;
      flowReq      <= 1'b0;
      flowChar     <= 8'h00;
      flowMask     <= '0;
    end else begin
      if (autoEvt) autoOn <= ~autoOn;
      forcePend <= (forcePend & ~forceGrant) | forceEvt;
      for (int i = 0; i < NUM_LINES; i++)
        if (forceEvt[i]) forcePendXon[i] <= forceEvtXon[i];
      if (autoEvt) begin
        autoPend    <= 1'b1;
        autoPendXon <= autoEvtXon;
      end else if (loadReq && !anyForce) begin
        autoPend <= 1'b0;
      end
      if (loadReq) begin
        if (anyForce) begin
          flowReq  <= 1'b1;
          flowChar <= forcePendXon[forceSel] ? CHAR_XON : CHAR_XOFF;
          flowMask <= forceGrant;
        end else if (autoPend) begin
          flowReq  <= 1'b1;
          flowChar <= autoPendXon ? CHAR_XON : CHAR_XOFF;
          flowMask <= '1;
        end else begin
          flowReq <= 1'b0;
        end
      end
    end
  end

  // ---------------- modem sampler ----------------
  logic [TW-1:0]          tickCnt;
  logic                   tick, anyStat;
  logic [3*NUM_LINES-1:0] modemPrev, statVal;
  logic [NUM_LINES-1:0]   statPend;
  logic [LW-1:0]          statSel;
  assign tick = (tickCnt == TW'(SAMPLE_PERIOD - 1));

  always_comb begin
    anyStat = 1'b0;
    statSel = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (statPend[i]) begin
        anyStat = 1'b1;
        statSel = LW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt   <= '0;
      modemPrev <= '0;
      statVal   <= '0;
      statPend  <= '0;
    end else begin
      tickCnt <= tick ? '0 : tickCnt + 1'b1;
      if (!rxValid && anyStat) statPend[statSel] <= 1'b0;
      if (tick) begin
        modemPrev <= modemIn;
        for (int i = 0; i < NUM_LINES; i++) begin
          if (modemIn[3*i +: 3] != modemPrev[3*i +: 3]) begin
            statPend[i]      <= 1'b1;
            statVal[3*i +: 3] <= modemIn[3*i +: 3];
          end
        end
      end
    end
  end

  // ---------------- strobes to datapath ----------------
  always_comb begin
    strobe.push   = rxValid | anyStat;
    strobe.word   = rxValid ? makeEntry(1'b0, 4'(rxLine), rxData)
                            : makeEntry(1'b1, 4'(statSel), {5'b0, statVal[3*statSel +: 3]});
    strobe.pop    = rdEn && !empty;
    strobe.clrOvr = ovrClr;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    flowReq && !flowAck |=> flowReq && $stable(flowChar) && $stable(flowMask)); // R9
  AST_FLOW_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    flowReq |-> (flowChar == CHAR_XOFF || flowChar == CHAR_XON)); // R4
  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    flowReq |-> (flowMask == '1 || $countones(flowMask) == 1)); // R6
  AST_RX_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push && strobe.word[12] |-> !rxValid); // R11

endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH         = 256,
  parameter int NUM_LINES     = 8,
  parameter int SAMPLE_PERIOD = 2000000,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rxValid,
  input  logic [LW-1:0]          rxLine,
  input  logic [7:0]             rxData,
  input  logic [3*NUM_LINES-1:0] modemIn,
  input  logic                   rdEn,
  output logic [15:0]            rdData,
  input  logic                   ovrClr,
  output logic                   overrun,
  input  logic [NUM_LINES-1:0]   forceXoff,
  output logic                   flowReq,
  output logic [7:0]             flowChar,
  output logic [NUM_LINES-1:0]   flowMask,
  input  logic                   flowAck
);
  siloStrobe_t   strobe;
  logic [CW-1:0] count;
  logic          empty;

  rx_silo_ctrl #(
    .DEPTH(DEPTH), .NUM_LINES(NUM_LINES), .SAMPLE_PERIOD(SAMPLE_PERIOD),
    .LW(LW), .CW(CW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxLine(rxLine), .rxData(rxData),
    .modemIn(modemIn), .rdEn(rdEn), .ovrClr(ovrClr), .forceXoff(forceXoff),
    .flowAck(flowAck), .count(count), .empty(empty), .strobe(strobe),
    .flowReq(flowReq), .flowChar(flowChar), .flowMask(flowMask)
  );

  rx_silo_data #(.DEPTH(DEPTH), .CW(CW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count), .empty(empty),
    .headWord(rdData), .overrun(overrun)
  );

endmodule

// File: tb/tb_rx_silo.sv
module tb_rx_silo;
  localparam int DEPTH  = 12;
  localparam int NL     = 4;
  localparam int PERIOD = 64;
  localparam int HIGH   = (2 * DEPTH) / 3;
  localparam int LOW    = DEPTH / 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic rxValid = 1'b0, rdEn = 1'b0, ovrClr = 1'b0, flowAck = 1'b0;
  logic [1:0] rxLine = '0;
  logic [7:0] rxData = '0;
  logic [3*NL-1:0] modemIn = '0;
  logic [NL-1:0] forceXoff = '0;
  logic [15:0] rdData;
  logic overrun, flowReq;
  logic [7:0] flowChar;
  logic [NL-1:0] flowMask;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_silo #(.DEPTH(DEPTH), .NUM_LINES(NL), .SAMPLE_PERIOD(PERIOD)) dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxLine(rxLine), .rxData(rxData),
    .modemIn(modemIn), .rdEn(rdEn), .rdData(rdData), .ovrClr(ovrClr),
    .overrun(overrun), .forceXoff(forceXoff), .flowReq(flowReq),
    .flowChar(flowChar), .flowMask(flowMask), .flowAck(flowAck)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] dataWord(input int line, input int d);
    return 16'h8000 | 16'(line << 8) | 16'(d & 8'hff);
  endfunction

  task automatic pushChar(input int line, input int d);
    @(negedge clk);
    rxValid = 1'b1; rxLine = 2'(line); rxData = 8'(d);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic readCheck(input logic [15:0] exp, input string tag);
    @(negedge clk);
    check(rdData == exp, tag, rdData, exp);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitReq(input logic [7:0] ch, input logic [NL-1:0] mask,
                         input bit ack, input string tag);
    int n = 0;
    @(negedge clk);
    while (!flowReq && n < 30) begin
      @(negedge clk);
      n++;
    end
    check(flowReq && flowChar == ch && flowMask == mask, tag,
          {flowReq, flowChar, 4'(flowMask)}, {1'b1, ch, 4'(mask)});
    if (ack) begin
      flowAck = 1'b1;
      @(negedge clk);
      flowAck = 1'b0;
    end
  endtask

  task automatic noReq(input int cycles, input string tag);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (flowReq) seen = 1;
    end
    check(!seen, tag, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData == 16'h0000 && !flowReq && !overrun, "R1 reset state",
          {rdData, flowReq, overrun}, 0);

    // R1/R2: words in arrival order, empty read
    for (int i = 0; i < 5; i++) pushChar(i % NL, 8'h30 + 7 * i);
    for (int i = 0; i < 5; i++) readCheck(dataWord(i % NL, 8'h30 + 7 * i), "R1 R2 data word order");
    readCheck(16'h0000, "R2 empty read shows zero");
    pushChar(3, 8'hA5);
    readCheck(dataWord(3, 8'hA5), "R2 word after empty read");

    // R4/R5/R3: thresholds and overflow
    for (int i = 0; i < HIGH - 1; i++) pushChar(i % NL, i);
    noReq(6, "R4 no XOFF below high mark");
    pushChar((HIGH - 1) % NL, HIGH - 1);
    waitReq(8'h13, 4'hF, 1, "R4 threshold XOFF");
    for (int i = HIGH; i < DEPTH; i++) pushChar(i % NL, i);
    noReq(6, "R5 no repeated XOFF while above mark");
    check(!overrun, "R3 no overrun at exact capacity", overrun, 0);
    pushChar(1, 8'hEE);
    @(negedge clk);
    check(overrun, "R3 overrun on push into full", overrun, 1);
    for (int i = 0; i < DEPTH - LOW - 1; i++) readCheck(dataWord(i % NL, i), "R3 kept words order");
    noReq(4, "R5 no XON above low mark");
    readCheck(dataWord((DEPTH - LOW - 1) % NL, DEPTH - LOW - 1), "R3 kept words order");
    waitReq(8'h11, 4'hF, 1, "R5 XON at low mark");
    for (int i = DEPTH - LOW; i < DEPTH; i++) readCheck(dataWord(i % NL, i), "R3 kept words order");
    readCheck(16'h0000, "R3 dropped word absent");
    check(overrun, "R3 overrun sticky", overrun, 1);
    @(negedge clk); ovrClr = 1'b1;
    @(negedge clk); ovrClr = 1'b0;
    @(negedge clk);
    check(!overrun, "R3 overrun cleared", overrun, 0);

    // R6/R7/R8: force-XOFF on line 2
    @(negedge clk); forceXoff = 4'b0100;
    waitReq(8'h13, 4'b0100, 1, "R6 force XOFF on rise");
    pushChar(2, 1);
    noReq(4, "R7 first forced char no XOFF");
    pushChar(2, 2);
    waitReq(8'h13, 4'b0100, 1, "R7 second forced char XOFF");
    pushChar(1, 3);
    pushChar(1, 4);
    noReq(4, "R7 other line chars ignored");
    pushChar(2, 5);
    noReq(4, "R7 third forced char no XOFF");
    pushChar(2, 6);
    waitReq(8'h13, 4'b0100, 1, "R7 fourth forced char XOFF");
    @(negedge clk); forceXoff = 4'b0000;
    waitReq(8'h11, 4'b0100, 1, "R8 XON on clear");
    readCheck(dataWord(2, 1), "R2 forced data order");
    readCheck(dataWord(2, 2), "R2 forced data order");
    readCheck(dataWord(1, 3), "R2 forced data order");
    readCheck(dataWord(1, 4), "R2 forced data order");
    readCheck(dataWord(2, 5), "R2 forced data order");
    readCheck(dataWord(2, 6), "R2 forced data order");

    // R9: hold and priority
    @(negedge clk); forceXoff = 4'b0001;
    waitReq(8'h13, 4'b0001, 0, "R9 first force request");
    repeat (5) @(negedge clk);
    check(flowReq && flowChar == 8'h13 && flowMask == 4'b0001, "R9 request held",
          {flowReq, flowChar, 4'(flowMask)}, {1'b1, 8'h13, 4'b0001});
    for (int i = 0; i < HIGH; i++) pushChar(1, 8'h50 + i);
    @(negedge clk); forceXoff = 4'b0101;
    repeat (4) @(negedge clk);
    waitReq(8'h13, 4'b0001, 1, "R9 still original request");
    waitReq(8'h13, 4'b0100, 1, "R9 force before threshold");
    waitReq(8'h13, 4'hF, 1, "R9 threshold after force");
    @(negedge clk); forceXoff = 4'b0000;
    waitReq(8'h11, 4'b0001, 1, "R9 lower line first");
    waitReq(8'h11, 4'b0100, 1, "R9 higher line next");
    for (int i = 0; i < HIGH; i++) readCheck(dataWord(1, 8'h50 + i), "R2 priority data order");
    waitReq(8'h11, 4'hF, 1, "R5 XON after drain");

    // R10: modem sampling
    @(negedge clk); modemIn = 12'b000_000_101_000;
    begin
      int n = 0;
      while (!rdData[15] && n < 3 * PERIOD) begin @(negedge clk); n++; end
    end
    readCheck(16'h9105, "R10 R1 status word on change");
    begin
      bit seen = 0;
      for (int i = 0; i < 2 * PERIOD + 4; i++) begin
        @(negedge clk);
        if (rdData[15]) seen = 1;
      end
      check(!seen, "R10 no word without change", seen, 0);
    end

    // R11: status word deferred behind a character stream
    @(negedge clk); modemIn = 12'b011_000_101_000;
    begin
      bit badStat = 0, found = 0;
      for (int i = 0; i < PERIOD + 16; i++) begin
        @(negedge clk);
        if (rdData[15] && rdData[12]) badStat = 1;
        rdEn = rdData[15];
        rxValid = 1'b1; rxLine = 2'd0; rxData = 8'(i);
      end
      @(negedge clk);
      rxValid = 1'b0; rdEn = 1'b0;
      check(!badStat, "R11 no status word during stream", badStat, 0);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (rdData == 16'h9303) found = 1;
        rdEn = rdData[15];
        @(negedge clk);
        rdEn = 1'b0;
      end
      check(found, "R11 status word pushed later", found, 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule